// File: doc/BRIEF.md
# Enhanced Path Remote Defect Code Generator

This block works out the three-bit enhanced remote defect code that the transmit side sends back to the far end in bits 5 to 7 of the path status overhead byte. It looks at the receive-side defect flags once per frame, on the frame strobe. The flags are loss of signal, loss of frame, line AIS, path AIS, loss of pointer, path unequipped and payload label mismatch. The block ranks these defects and turns them into one of four codes. Inserting the code into the byte stream is done elsewhere.

A new code must stay on the line for a minimum number of frames before it can drop to a less severe code. A more severe defect never waits: it takes effect at the next strobe and starts a new hold. When automatic generation is switched off, the output carries a three-bit value written by the processor instead.

Top module: `prdi_gen`

## Requirements
- R1: After reset, the automatic code is 001 and no hold is running. The automatic code only ever takes the values 101, 110, 010 or 001.
- R2: At a frame strobe, if any of loss of signal, loss of frame, line AIS, path AIS or loss of pointer is asserted, the code becomes 101. This takes effect one clock after the strobe.
- R3: At a frame strobe, path unequipped with none of the R2 defects gives code 110, unless a more severe code is being held.
- R4: At a frame strobe, payload label mismatch with no unequipped and no R2 defect gives code 010, unless a more severe code is being held.
- R5: At a frame strobe with no defect asserted, the target code is 001.
- R6: Defect flags are sampled only on a clock where frame_tick is high. Between strobes the code does not change.
- R7: A target code of higher priority replaces the current code at the next strobe, even during a hold, and restarts the hold of HOLD_FRAMES (20) strobes. The priority order from highest to lowest is 101, 110, 010, 001.
- R8: A target of equal or lower priority, including the cleared state, waits until the current code has been on for HOLD_FRAMES strobes. It therefore appears at the 20th strobe after the change, never earlier.
- R9: While auto_en is low, g1_code equals cpu_code in the same cycle. While auto_en is high, g1_code shows the automatic code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle frame strobe |
| los | input | 1 | Loss of signal |
| lof | input | 1 | Loss of frame |
| ais_line | input | 1 | Line alarm indication signal |
| ais_path | input | 1 | Path alarm indication signal |
| lop | input | 1 | Loss of pointer |
| uneq | input | 1 | Path unequipped |
| plm | input | 1 | Payload label mismatch |
| auto_en | input | 1 | Selects automatic code generation |
| cpu_code | input | 3 | Processor value sent when automatic generation is off |
| g1_code | output | 3 | Code for bits 5 to 7 of the path status byte |

## Verification
Two functions can meet at the same strobe: the expiry of the running hold and the arrival of a new target code. A lower-priority target can also meet a higher-priority escalation while the hold is still running. The bench provokes the first case by keeping a less severe defect pattern applied through the whole hold. It then checks that the code is unchanged after the 19th strobe and has switched after the 20th. For the second case it raises unequipped or a server defect partway through a label-mismatch or unequipped hold. It judges the result by the immediate code change and by a full fresh 20-strobe hold that follows.

// File: rtl/prdi_pkg.sv
package prdi_pkg;
   localparam int CODE_W = 3;
   typedef logic [CODE_W-1:0] rdi_code_t;

   localparam rdi_code_t CODE_SRV  = 3'b101;
   localparam rdi_code_t CODE_UNEQ = 3'b110;
   localparam rdi_code_t CODE_PLM  = 3'b010;
   localparam rdi_code_t CODE_NONE = 3'b001;

   // Severity rank: larger wins
   function automatic logic [1:0] code_rank(input rdi_code_t c);
      case (c)
         CODE_SRV:  code_rank = 2'd3;
         CODE_UNEQ: code_rank = 2'd2;
         CODE_PLM:  code_rank = 2'd1;
         default:   code_rank = 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/prdi_classify.sv
module prdi_classify
   import prdi_pkg::*;
#(
   parameter int N_SRV = 5
) (
   input  logic [N_SRV-1:0] srv_def,
   input  logic             uneq,
   input  logic             plm,
   output rdi_code_t        want
);
   generate
      if (N_SRV < 1) begin : g_bad
         $error("prdi_classify: N_SRV must be at least 1");
      end
   endgenerate

   logic any_srv;
   assign any_srv = |srv_def;

   always_comb begin
      if (any_srv)   want = CODE_SRV;
      else if (uneq) want = CODE_UNEQ;
      else if (plm)  want = CODE_PLM;
      else           want = CODE_NONE;
   end
endmodule

// File: rtl/prdi_hold.sv
module prdi_hold
   import prdi_pkg::*;
#(
   parameter int HOLD_FRAMES = 20,
   localparam int CNT_W = $clog2(HOLD_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_tick,
   input  rdi_code_t        want,
   output rdi_code_t        held,
   output logic [CNT_W-1:0] hold_left
);
   generate
      if (HOLD_FRAMES < 2) begin : g_bad
         $error("prdi_hold: HOLD_FRAMES must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_FRAMES - 1);

   logic escalate, expired, take;
   assign escalate = code_rank(want) > code_rank(held);
   assign expired  = (hold_left == '0);
   assign take     = escalate || (expired && (want != held));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= CODE_NONE;
         hold_left <= '0;
      end else if (frame_tick) begin
         if (take) begin
            held      <= want;
            hold_left <= RELOAD;
         end else if (!expired) begin
            hold_left <= hold_left - 1'b1;
         end
      end
   end
endmodule

// File: rtl/prdi_gen.sv
module prdi_gen
   import prdi_pkg::*;
#(
   parameter int HOLD_FRAMES = 20,
   parameter bit OUT_REG     = 1'b0,
   localparam int CNT_W = $clog2(HOLD_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_tick,
   input  logic             los,
   input  logic             lof,
   input  logic             ais_line,
   input  logic             ais_path,
   input  logic             lop,
   input  logic             uneq,
   input  logic             plm,
   input  logic             auto_en,
   input  logic [CODE_W-1:0] cpu_code,
   output logic [CODE_W-1:0] g1_code
);
   localparam int N_SRV = 5;

   rdi_code_t        want_code;
   rdi_code_t        auto_code;
   logic [CNT_W-1:0] hold_left;
   rdi_code_t        sel_code;

   prdi_classify #(.N_SRV(N_SRV)) u_cls (
      .srv_def ({los, lof, ais_line, ais_path, lop}),
      .uneq    (uneq),
      .plm     (plm),
      .want    (want_code)
   );

   prdi_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .want       (want_code),
      .held       (auto_code),
      .hold_left  (hold_left)
   );

   assign sel_code = auto_en ? auto_code : rdi_code_t'(cpu_code);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) g1_code <= CODE_NONE;
            else        g1_code <= sel_code;
         end
      end else begin : g_comb
         assign g1_code = sel_code;
      end
   endgenerate
endmodule

// File: rtl/prdi_gen_chk.sv
module prdi_gen_chk
   import prdi_pkg::*;
#(
   parameter int HOLD_FRAMES = 20,
   parameter bit OUT_REG     = 1'b0,
   localparam int CNT_W = $clog2(HOLD_FRAMES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_tick,
   input logic             los,
   input logic             lof,
   input logic             ais_line,
   input logic             ais_path,
   input logic             lop,
   input logic             uneq,
   input logic             auto_en,
   input logic [CODE_W-1:0] cpu_code,
   input logic [CODE_W-1:0] g1_code,
   input rdi_code_t        want_code,
   input rdi_code_t        auto_code,
   input logic [CNT_W-1:0] hold_left
);
   logic srv;
   assign srv = los | lof | ais_line | ais_path | lop;

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_code == CODE_SRV) || (auto_code == CODE_UNEQ) ||
      (auto_code == CODE_PLM) || (auto_code == CODE_NONE)); // R1

   AST_SRV_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && srv |=> auto_code == CODE_SRV); // R2

   AST_UNEQ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && uneq && !srv && (code_rank(auto_code) <= 2'd2)
      |=> auto_code == CODE_UNEQ); // R3

   AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(auto_code)); // R6

   AST_ESCALATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && (code_rank(want_code) > code_rank(auto_code))
      |=> (auto_code == $past(want_code)) && (hold_left == CNT_W'(HOLD_FRAMES - 1))); // R7

   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && (hold_left != '0) && (code_rank(want_code) <= code_rank(auto_code))
      |=> $stable(auto_code)); // R8

   generate
      if (!OUT_REG) begin : g_man
         AST_MANUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en |-> g1_code == cpu_code); // R9
      end
   endgenerate
endmodule

bind prdi_gen prdi_gen_chk #(.HOLD_FRAMES(HOLD_FRAMES), .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .los        (los),
   .lof        (lof),
   .ais_line   (ais_line),
   .ais_path   (ais_path),
   .lop        (lop),
   .uneq       (uneq),
   .auto_en    (auto_en),
   .cpu_code   (cpu_code),
   .g1_code    (g1_code),
   .want_code  (want_code),
   .auto_code  (auto_code),
   .hold_left  (hold_left)
);

// File: tb/tb_prdi_gen.sv
`timescale 1ns/1ps
module tb_prdi_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_tick = 1'b0;
   logic los = 0, lof = 0, ais_line = 0, ais_path = 0, lop = 0, uneq = 0, plm = 0;
   logic auto_en = 1'b1;
   logic [2:0] cpu_code = 3'b000;
   logic [2:0] g1_code;
   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   prdi_gen dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .los(los), .lof(lof), .ais_line(ais_line), .ais_path(ais_path),
      .lop(lop), .uneq(uneq), .plm(plm),
      .auto_en(auto_en), .cpu_code(cpu_code), .g1_code(g1_code)
   );

   task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   // order: los lof ais_line ais_path lop uneq plm
   task automatic set_def(input logic [6:0] v);
      {los, lof, ais_line, ais_path, lop, uneq, plm} = v;
   endtask

   task automatic tick();
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // Code must stay for 19 strobes, then change on the 20th (R8)
   task automatic hold_then(input logic [2:0] held_exp, input logic [2:0] next_exp);
      ticks(19);
      check("R8 held through hold", g1_code, held_exp);
      tick();
      check("R8 change at hold expiry", g1_code, next_exp);
   endtask

   task automatic t_reset();
      check("R1 reset code", g1_code, 3'b001);
      tick();
      check("R5 no defect stays 001", g1_code, 3'b001);
   endtask

   task automatic t_server();
      for (int k = 0; k < 5; k++) begin
         set_def(7'b1000000 >> k);
         tick();
         check("R2 server defect", g1_code, 3'b101);
         set_def(7'b0);
         hold_then(3'b101, 3'b001);
      end
   endtask

   task automatic t_uneq_escalate();
      set_def(7'b0000010);
      tick();
      check("R3 unequipped", g1_code, 3'b110);
      set_def(7'b0000011);
      tick();
      check("R3 unequipped over mismatch", g1_code, 3'b110);
      set_def(7'b1000011);
      tick();
      check("R7 server during hold", g1_code, 3'b101);
      set_def(7'b0);
      hold_then(3'b101, 3'b001);
   endtask

   task automatic t_plm_escalate();
      set_def(7'b0000001);
      tick();
      check("R4 label mismatch", g1_code, 3'b010);
      ticks(5);
      set_def(7'b0000011);
      tick();
      check("R7 unequipped during mismatch hold", g1_code, 3'b110);
      set_def(7'b0);
      hold_then(3'b110, 3'b001);
   endtask

   task automatic t_step_down();
      set_def(7'b0010000);
      tick();
      check("R2 line AIS", g1_code, 3'b101);
      set_def(7'b0000001);
      hold_then(3'b101, 3'b010);
      set_def(7'b0);
      hold_then(3'b010, 3'b001);
   endtask

   task automatic t_no_tick();
      set_def(7'b0100000);
      repeat (10) @(negedge clk);
      check("R6 no strobe no change", g1_code, 3'b001);
      tick();
      check("R6 sampled on strobe", g1_code, 3'b101);
      set_def(7'b0);
      hold_then(3'b101, 3'b001);
   endtask

   task automatic t_manual();
      @(negedge clk);
      auto_en = 1'b0;
      cpu_code = 3'b111;
      #1 check("R9 manual value", g1_code, 3'b111);
      set_def(7'b0000001);
      tick();
      check("R9 manual ignores defects", g1_code, 3'b111);
      cpu_code = 3'b000;
      #1 check("R9 manual follows cpu", g1_code, 3'b000);
      auto_en = 1'b1;
      #1 check("R9 auto restored", g1_code, 3'b010);
      set_def(7'b0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_server();
      t_uneq_escalate();
      t_plm_escalate();
      t_step_down();
      t_no_tick();
      t_manual();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule